// File: doc/BRIEF.md
# Multi-Mode 16-Bit Core Timer

This block is a 16-bit up/down timer clocked from the system clock. Software programs it with a 10-bit control word. The word sets a run bit, an operating mode, a count direction and a 3-bit select field. The counter value can be written and read back at any time. Each wrap of the counter past its end sets a sticky interrupt request flag, which software clears with a strobe. Each wrap also flips a toggle latch, and that latch can be shown on an output pin.

There are three operating modes. In timer mode the counter steps once per period of a power-of-two prescaler. In gated mode the prescaler advances only while an external gate input is at its active level, which lets software measure pulse widths. In event-counter mode the prescaler is bypassed and qualified transitions of the same external input step the counter. The external input is synchronized before use. Direction comes either from the control word or from an external pin.

Top module: `mm_core_timer`

## Requirements
- R1: After reset the count is 0000h, the interrupt flag is 0, the toggle output is 0 and the control word is all zero (stopped, timer mode, counting up).
- R2: The control word fields are sel = bits [2:0], mode = bits [5:3], run = bit 6, down = bit 7, extDir = bit 8 and outEn = bit 9. A control write takes effect from the next cycle. In timer mode (mode 000) with run set, the counter moves by exactly one step every 2^(3+sel) clock cycles. The first step comes 2^(3+sel) cycles after the edge that wrote run.
- R3: When extDir is 0, down = 0 counts up and down = 1 counts down. When extDir is 1, the dirIn pin sets the direction (1 = down, 0 = up) cycle by cycle, and the down bit has no effect.
- R4: An up step from FFFFh or a down step from 0000h sets irqFlag on that edge. The flag stays set until irqClr is pulsed. A wrap in the same cycle as irqClr wins, so the flag stays set.
- R5: Every wrap inverts an internal toggle latch. toggleOut shows the latch when outEn is 1 and is 0 when outEn is 0.
- R6: In gated modes the prescaler advances only while the synchronized extIn is high (mode 010) or low (mode 011). While the gate is closed, the prescaler and the count hold.
- R7: In event-counter mode (mode 001), sel[0] = 1 counts rising edges of extIn and sel[1] = 1 counts falling edges; sel = x00 counts nothing. extIn passes through two flip-flops. A change applied before clock edge a moves the count at edge a+2.
- R8: A counter write loads cntWrData on that edge and overrides any count step in the same cycle. That step produces no wrap.
- R9: With run clear the count holds and the prescaler is held at zero. After run is set again, the first step comes a full prescale period later.
- R10: If N-1 is loaded with down counting in timer mode, the flag sets on the N-th step, at the wrap from 0000h to FFFFh.
- R11: Mode codes 100 to 111 do not count, even with run set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWrEn | input | 1 | Control word write strobe |
| ctrlWrData | input | 10 | Control word value |
| cntWrEn | input | 1 | Counter write strobe |
| cntWrData | input | 16 | Counter value to load |
| cntRdData | output | 16 | Current counter value |
| extIn | input | 1 | External gate or event input (asynchronous) |
| dirIn | input | 1 | External direction input, 1 = down |
| irqClr | input | 1 | Clears the interrupt request flag |
| irqFlag | output | 1 | Sticky wrap flag |
| toggleOut | output | 1 | Toggle latch output, gated by outEn |

## Verification
The bench goes after the wrap boundaries in both directions. A design with an off-by-one compare there would set the flag one step early or late, or would miss the N-th tick in the load-N-1 countdown. It checks the two-cycle synchronizer latency and the chosen edge polarity in event mode; a design that skipped the synchronizer or counted the wrong edge would move the count at the wrong edge. It checks that stopping resets the prescaler, since a design that kept the partial prescale would restart with a short first period. It also hits cycles where a counter write, a step and a flag clear all land together. A design with the wrong priority there would lose the loaded value or drop a new wrap.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int TMR_SEL_W       = 3;
  localparam int TMR_PRE_MIN_EXP = 3;
  localparam int TMR_CTRL_W      = 10;

  localparam logic [2:0] MODE_TIMER   = 3'b000;
  localparam logic [2:0] MODE_COUNT   = 3'b001;
  localparam logic [2:0] MODE_GATE_HI = 3'b010;
  localparam logic [2:0] MODE_GATE_LO = 3'b011;

  typedef struct packed {
    logic                 outEn;
    logic                 extDir;
    logic                 down;
    logic                 run;
    logic [2:0]           mode;
    logic [TMR_SEL_W-1:0] sel;
  } tmrCtrl_t;

  typedef struct packed {
    logic step;
    logic up;
  } tmrStrobe_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctrlWrEn,
  input  tmrCtrl_t   ctrlWrData,
  input  logic       extIn,
  input  logic       dirIn,
  output tmrCtrl_t   ctrlQ,
  output tmrStrobe_t strb
);
  localparam int PRE_W = TMR_PRE_MIN_EXP + (1 << TMR_SEL_W) - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   extSync;
  logic                   extPrev;
  logic                   rise;
  logic                   fall;
  logic [PRE_W-1:0]       preQ;
  logic [PRE_W:0]         preFull;
  logic [PRE_W-1:0]       preLast;
  logic                   usePre;
  logic                   gateOpen;
  logic                   preEn;
  logic                   preTick;
  logic                   evTick;

  always_ff @(posedge clk) begin
    if (!rstN) ctrlQ <= '0;
    else if (ctrlWrEn) ctrlQ <= ctrlWrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ   <= '0;
      extPrev <= 1'b0;
    end else begin
      syncQ   <= {syncQ[SYNC_STAGES-2:0], extIn};
      extPrev <= syncQ[SYNC_STAGES-1];
    end
  end

  assign extSync = syncQ[SYNC_STAGES-1];
  assign rise    = extSync & ~extPrev;
  assign fall    = ~extSync & extPrev;

  always_comb begin
    preFull  = ({{PRE_W{1'b0}}, 1'b1} << (TMR_PRE_MIN_EXP + int'(ctrlQ.sel))) - 1'b1;
    preLast  = preFull[PRE_W-1:0];
    usePre   = 1'b0;
    gateOpen = 1'b0;
    case (ctrlQ.mode)
      MODE_TIMER:   begin usePre = 1'b1; gateOpen = 1'b1;     end
      MODE_GATE_HI: begin usePre = 1'b1; gateOpen = extSync;  end
      MODE_GATE_LO: begin usePre = 1'b1; gateOpen = ~extSync; end
      default:      begin usePre = 1'b0; gateOpen = 1'b0;     end
    endcase
    preEn   = ctrlQ.run & usePre & gateOpen;
    preTick = preEn & (preQ >= preLast);
    evTick  = ctrlQ.run & (ctrlQ.mode == MODE_COUNT) &
              ((ctrlQ.sel[0] & rise) | (ctrlQ.sel[1] & fall));
    strb.step = preTick | evTick;
    strb.up   = ctrlQ.extDir ? ~dirIn : ~ctrlQ.down;
  end

  always_ff @(posedge clk) begin
    if (!rstN) preQ <= '0;
    else if (!(ctrlQ.run & usePre)) preQ <= '0;
    else if (preEn) preQ <= preTick ? '0 : preQ + 1'b1;
  end
endmodule

// File: rtl/tmr_dpath.sv
module tmr_dpath
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strb,
  input  logic             cntWrEn,
  input  logic [CNT_W-1:0] cntWrData,
  input  logic             irqClr,
  input  logic             outEn,
  output logic [CNT_W-1:0] cntQ,
  output logic             irqFlag,
  output logic             toggleOut
);
  logic wrapHit;
  logic togQ;

  assign wrapHit = strb.step & ~cntWrEn & (strb.up ? (&cntQ) : ~(|cntQ));

  always_ff @(posedge clk) begin
    if (!rstN) cntQ <= '0;
    else if (cntWrEn) cntQ <= cntWrData;
    else if (strb.step) cntQ <= strb.up ? cntQ + CNT_W'(1) : cntQ - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqFlag <= 1'b0;
      togQ    <= 1'b0;
    end else begin
      if (wrapHit) irqFlag <= 1'b1;
      else if (irqClr) irqFlag <= 1'b0;
      togQ <= togQ ^ wrapHit;
    end
  end

  assign toggleOut = togQ & outEn;
endmodule

// File: rtl/mm_core_timer.sv
module mm_core_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  ctrlWrEn,
  input  logic [TMR_CTRL_W-1:0] ctrlWrData,
  input  logic                  cntWrEn,
  input  logic [CNT_W-1:0]      cntWrData,
  output logic [CNT_W-1:0]      cntRdData,
  input  logic                  extIn,
  input  logic                  dirIn,
  input  logic                  irqClr,
  output logic                  irqFlag,
  output logic                  toggleOut
);
  tmrCtrl_t   ctrlQ;
  tmrStrobe_t strb;

  tmr_ctrl #(.SYNC_STAGES(2)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .ctrlWrEn   (ctrlWrEn),
    .ctrlWrData (tmrCtrl_t'(ctrlWrData)),
    .extIn      (extIn),
    .dirIn      (dirIn),
    .ctrlQ      (ctrlQ),
    .strb       (strb)
  );

  tmr_dpath #(.CNT_W(CNT_W)) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cntWrEn   (cntWrEn),
    .cntWrData (cntWrData),
    .irqClr    (irqClr),
    .outEn     (ctrlQ.outEn),
    .cntQ      (cntRdData),
    .irqFlag   (irqFlag),
    .toggleOut (toggleOut)
  );
endmodule

// File: rtl/mm_core_timer_chk.sv
module mm_core_timer_chk
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             cntWrEn,
  input logic [CNT_W-1:0] cntWrData,
  input logic             irqClr,
  input logic [CNT_W-1:0] cntRdData,
  input logic             irqFlag,
  input logic             toggleOut,
  input tmrCtrl_t         ctrlQ,
  input tmrStrobe_t       strb
);
  p_write_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    cntWrEn |=> cntRdData == $past(cntWrData));

  p_single_up_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!cntWrEn && strb.step && strb.up) |=> cntRdData == $past(cntRdData) + CNT_W'(1));

  p_single_down_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!cntWrEn && strb.step && !strb.up) |=> cntRdData == $past(cntRdData) - CNT_W'(1));

  p_hold_no_step_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!cntWrEn && !strb.step) |=> $stable(cntRdData));

  p_stopped_no_step_r9: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlQ.run |-> !strb.step);

  p_reserved_mode_r11: assert property (@(posedge clk) disable iff (!rstN)
    ctrlQ.mode[2] |-> !strb.step);

  p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !irqClr) |=> irqFlag);

  p_wrap_sets_flag_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!cntWrEn && strb.step && strb.up && (&cntRdData)) |=> irqFlag);

  p_toggle_masked_r5: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlQ.outEn |-> !toggleOut);
endmodule

bind mm_core_timer mm_core_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .cntWrEn   (cntWrEn),
  .cntWrData (cntWrData),
  .irqClr    (irqClr),
  .cntRdData (cntRdData),
  .irqFlag   (irqFlag),
  .toggleOut (toggleOut),
  .ctrlQ     (ctrlQ),
  .strb      (strb)
);

// File: tb/mm_core_timer_tb_top.sv
module mm_core_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RAND_CYCLES = 30000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctrlWrEn = 1'b0;
  logic [9:0]  ctrlWrData = '0;
  logic        cntWrEn = 1'b0;
  logic [15:0] cntWrData = '0;
  logic [15:0] cntRdData;
  logic        extIn = 1'b0;
  logic        dirIn = 1'b0;
  logic        irqClr = 1'b0;
  logic        irqFlag;
  logic        toggleOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  mm_core_timer dut_i (
    .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .cntWrEn(cntWrEn), .cntWrData(cntWrData), .cntRdData(cntRdData),
    .extIn(extIn), .dirIn(dirIn), .irqClr(irqClr), .irqFlag(irqFlag),
    .toggleOut(toggleOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference state, stepped from the requirements
  logic [9:0]  mCtrl;
  logic [15:0] mCnt;
  logic        mFlag, mTog, ms1, ms2, ms3;
  int          mPre;

  function automatic bit gateOk(input logic [2:0] mode, input logic s);
    case (mode)
      3'b000: return 1'b1;
      3'b010: return s;
      3'b011: return !s;
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCtrl = '0; mCnt = '0; mFlag = 0; mTog = 0; ms1 = 0; ms2 = 0; ms3 = 0; mPre = 0;
    end else begin
      logic [2:0] mode;
      logic [2:0] sel;
      bit run, up, prescaled, tickP, tickE, step, wrap;
      int ratio;
      mode = mCtrl[5:3]; sel = mCtrl[2:0]; run = mCtrl[6];
      up = mCtrl[8] ? !dirIn : !mCtrl[7];
      prescaled = (mode == 3'b000) || (mode == 3'b010) || (mode == 3'b011);
      ratio = 1 << (3 + sel);
      tickP = run && prescaled && gateOk(mode, ms2) && (mPre >= ratio - 1);
      tickE = run && (mode == 3'b001) &&
              ((sel[0] && ms2 && !ms3) || (sel[1] && !ms2 && ms3));
      step = tickP || tickE;
      wrap = step && !cntWrEn && (up ? (mCnt == 16'hFFFF) : (mCnt == 16'h0000));
      if (!(run && prescaled)) mPre = 0;
      else if (gateOk(mode, ms2)) mPre = tickP ? 0 : mPre + 1;
      if (cntWrEn) mCnt = cntWrData;
      else if (step) mCnt = up ? mCnt + 16'd1 : mCnt - 16'd1;
      if (wrap) mFlag = 1;
      else if (irqClr) mFlag = 0;
      mTog = mTog ^ wrap;
      ms3 = ms2; ms2 = ms1; ms1 = extIn;
      if (ctrlWrEn) mCtrl = ctrlWrData;
    end
  end

  // Lockstep comparison away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      checks += 3;
      if (cntRdData !== mCnt) begin
        errors++; $display("FAIL R2 count: actual %h expected %h", cntRdData, mCnt);
      end
      if (irqFlag !== mFlag) begin
        errors++; $display("FAIL R4 flag: actual %b expected %b", irqFlag, mFlag);
      end
      if (toggleOut !== (mTog & mCtrl[9])) begin
        errors++; $display("FAIL R5 toggle: actual %b expected %b", toggleOut, mTog & mCtrl[9]);
      end
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [9:0] cw(input bit outEn, input bit extDir, input bit down,
                                    input bit run, input logic [2:0] mode, input logic [2:0] sel);
    return {outEn, extDir, down, run, mode, sel};
  endfunction

  task automatic writeCtrl(input logic [9:0] v);
    ctrlWrEn = 1'b1; ctrlWrData = v;
    idle(1);
    ctrlWrEn = 1'b0;
  endtask

  task automatic writeCnt(input logic [15:0] v);
    cntWrEn = 1'b1; cntWrData = v;
    idle(1);
    cntWrEn = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic t0;
    void'($urandom(32'h5EED_0042));
    idle(3);
    rstN = 1'b1;
    idle(1);
    // R1 reset state
    check("R1 count", cntRdData, 16'h0000);
    check("R1 flag", {15'd0, irqFlag}, 16'd0);
    check("R1 toggle", {15'd0, toggleOut}, 16'd0);

    // R10: load N-1 = 4, count down at /8, flag after 5 steps (40 cycles)
    writeCnt(16'd4);
    writeCtrl(cw(0, 0, 1, 1, 3'b000, 3'd0));
    idle(39);
    check("R10 flag before Nth tick", {15'd0, irqFlag}, 16'd0);
    idle(1);
    check("R10 flag on Nth tick", {15'd0, irqFlag}, 16'd1);
    check("R10 count wrapped", cntRdData, 16'hFFFF);
    irqClr = 1'b1; idle(1); irqClr = 1'b0;
    check("R4 flag cleared", {15'd0, irqFlag}, 16'd0);

    // R9: stop holds count, restart gives a full prescale period
    writeCtrl(cw(0, 0, 0, 0, 3'b000, 3'd0));
    writeCnt(16'd100);
    writeCtrl(cw(0, 0, 0, 1, 3'b000, 3'd0));
    idle(20);
    check("R2 two steps in 20 cycles", cntRdData, 16'd102);
    writeCtrl(cw(0, 0, 0, 0, 3'b000, 3'd0));
    idle(30);
    check("R9 held while stopped", cntRdData, 16'd102);
    writeCtrl(cw(0, 0, 0, 1, 3'b000, 3'd0));
    idle(7);
    check("R9 no short first period", cntRdData, 16'd102);
    idle(1);
    check("R9 first step after full period", cntRdData, 16'd103);

    // R7: rising-edge event count, two-flop latency
    writeCtrl(cw(0, 0, 0, 1, 3'b001, 3'b001));
    writeCnt(16'd0);
    extIn = 1'b1;
    idle(2);
    check("R7 not yet counted", cntRdData, 16'd0);
    idle(1);
    check("R7 rising edge counted", cntRdData, 16'd1);
    extIn = 1'b0;
    idle(6);
    check("R7 falling edge ignored", cntRdData, 16'd1);

    // R11: reserved mode does not count
    writeCtrl(cw(0, 0, 0, 1, 3'b101, 3'd0));
    idle(50);
    check("R11 reserved mode holds", cntRdData, 16'd1);

    // R6: gate high mode with gate closed holds
    writeCtrl(cw(0, 0, 0, 1, 3'b010, 3'd0));
    writeCnt(16'd0);
    idle(40);
    check("R6 gate closed holds", cntRdData, 16'd0);

    // R3: external direction overrides the direction bit
    dirIn = 1'b1;
    writeCtrl(cw(0, 0, 0, 0, 3'b000, 3'd0));
    writeCnt(16'd10);
    writeCtrl(cw(0, 1, 0, 1, 3'b000, 3'd0));
    idle(8);
    check("R3 pin selects down", cntRdData, 16'd9);
    dirIn = 1'b0;

    // R5 / R4: overflow toggles latch and sets flag
    writeCtrl(cw(0, 0, 0, 0, 3'b000, 3'd0));
    writeCnt(16'hFFFF);
    writeCtrl(cw(1, 0, 0, 1, 3'b000, 3'd0));
    t0 = toggleOut;
    idle(8);
    check("R5 toggle flipped", {15'd0, toggleOut}, {15'd0, ~t0});
    check("R4 overflow sets flag", {15'd0, irqFlag}, 16'd1);
    check("R4 count wrapped to zero", cntRdData, 16'h0000);

    // R8: write overrides step
    writeCtrl(cw(0, 0, 0, 0, 3'b000, 3'd0));
    writeCnt(16'h1234);
    check("R8 loaded value", cntRdData, 16'h1234);

    // Random phase, checked in lockstep
    for (int i = 0; i < RAND_CYCLES; i++) begin
      ctrlWrEn = ($urandom_range(0, 199) == 0);
      if (ctrlWrEn) begin
        logic [2:0] m;
        m = ($urandom_range(0, 9) == 0) ? 3'($urandom_range(4, 7)) : 3'($urandom_range(0, 3));
        ctrlWrData = cw(1'($urandom), 1'($urandom), 1'($urandom),
                        ($urandom_range(0, 7) != 0), m, 3'($urandom_range(0, 2)));
      end
      cntWrEn = ($urandom_range(0, 149) == 0);
      if (cntWrEn) begin
        case ($urandom_range(0, 4))
          0: cntWrData = 16'hFFFF;
          1: cntWrData = 16'hFFFE;
          2: cntWrData = 16'h0000;
          3: cntWrData = 16'h0001;
          default: cntWrData = 16'($urandom);
        endcase
      end
      irqClr = ($urandom_range(0, 19) == 0);
      if ($urandom_range(0, 5) == 0) extIn = ~extIn;
      if ($urandom_range(0, 49) == 0) dirIn = ~dirIn;
      idle(1);
    end
    ctrlWrEn = 1'b0; cntWrEn = 1'b0; irqClr = 1'b0;
    idle(2);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule